// File: doc/BRIEF.md
# Self-Synchronizing Pattern Error Checker

This block checks a received serial bit stream against a reference pattern that it generates itself. One bit arrives per clock cycle in which `bit_valid` is high. The reference is either a pseudo-random binary sequence of a selectable order or a 16-bit programmable word repeated without end. The block compares every received bit with its reference bit and counts each mismatch as one bit error.

Errors are judged over fixed windows of 256 compared bits. When a window holds too many errors for the current mode, the block drops lock and aligns itself again. In PRBS mode it loads its reference register straight from the incoming bits for n bits and then lets it run freely. In word mode it holds the reference back by one bit position and tries the next window. Outputs are the lock flag, a one-cycle pulse for each bit error seen while locked, and an error count that saturates at its maximum and clears on request.

Top module: `patchk_top`

## Requirements
- R1: `prbs_sel` picks the order n and middle tap m: 0 gives n=7,m=6; 1 gives 15,14; 2 gives 17,14; 3 gives 20,3; 4 gives 23,18. The reference obeys b[k] = b[k-n] XOR b[k-m], which has period 2^n-1.
- R2: In PRBS mode (`mode_word`=0), the first n valid bits after reset, and the first n valid bits after a loss of lock, are loaded into the reference and are not compared. A window of 256 compared bits follows. If that window holds fewer than 64 errors, `locked` is high after the last bit of the window, so with clean data it first reads high after bit index n+255, counting from 0.
- R3: In PRBS mode, a window with 64 or more errors drops `locked` after its last bit. A window with exactly 63 errors keeps lock.
- R4: In word mode (`mode_word`=1), the reference sends `word_pat` bit 15 first, then the lower bits in turn down to bit 0, and then repeats. An aligned stream locks after bit index 255.
- R5: In word mode, a window with 8 or more errors moves the reference back by one bit position: the reference bit of the last bit of the window is used once more for the next bit, and the next window starts at once. A stream whose bit k is `word_pat`[15-((k+p) mod 16)] therefore locks after bit index 256*(((16-p) mod 16)+1)-1.
- R6: In word mode, a locked window with 8 or more errors drops `locked`. A window with exactly 7 errors keeps lock.
- R7: `err_pulse` is high for one cycle after each valid bit that mismatches while the block is locked, and is low after a bit that matches.
- R8: `err_count` goes up by one for each error counted while the block is locked. It does not change during seeding or during the search for alignment.
- R9: `err_count` stops at its all-ones value. `cnt_clear` sets it to zero on the next edge and takes priority over an increment.
- R10: Cycles with `bit_valid` low change neither the lock state, the reference position nor the counters, whatever `rx_bit` is.
- R11: After reset `locked`, `err_pulse` and `err_count` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | A received bit is present on `rx_bit` this cycle |
| rx_bit | input | 1 | Received serial data bit |
| mode_word | input | 1 | 0: PRBS reference, 1: programmable word reference |
| prbs_sel | input | 3 | PRBS order select, encoded as in R1 |
| word_pat | input | 16 | Programmable word, bit 15 sent first |
| cnt_clear | input | 1 | Synchronous clear of the error count |
| locked | output | 1 | Pattern alignment achieved |
| err_pulse | output | 1 | One-cycle flag for a bit error while locked |
| err_count | output | CNT_W (32) | Saturating count of errors seen while locked |

## Verification
The checker asserts on every cycle that the count moves by at most one, stays still while unlocked or idle, saturates, and clears when asked. It also asserts that an error pulse only follows a valid bit seen while locked, that lock is only gained at the end of a clean window and always lost after a bad one, and that a slip happens only in word mode. Only the directed scenarios can show the exact lock times for each PRBS order and each word phase, the 63/64 and 7/8 error boundaries, and relock after loss. They can also show that an inverted PRBS stream never locks and that idle cycles with noise on the data input leave no trace.

// File: rtl/patchk_pkg.sv
package patchk_pkg;

  localparam int HIST_W = 23;
  localparam int SEL_W  = 3;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEED = 2'd1,
    ST_HUNT = 2'd2,
    ST_LOCK = 2'd3
  } sync_st_e;

  // register length n for the selected order
  function automatic logic [4:0] prbs_len(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd1:    return 5'd15;
      3'd2:    return 5'd17;
      3'd3:    return 5'd20;
      3'd4:    return 5'd23;
      default: return 5'd7;
    endcase
  endfunction

  // middle feedback tap m for the selected order
  function automatic logic [4:0] prbs_mid(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd1:    return 5'd14;
      3'd2:    return 5'd14;
      3'd3:    return 5'd3;
      3'd4:    return 5'd18;
      default: return 5'd6;
    endcase
  endfunction

  // next bit: h[0] is the newest bit, so h[j-1] is b[k-j]
  function automatic logic prbs_fb(input logic [HIST_W-1:0] h,
                                   input logic [SEL_W-1:0] sel);
    logic [4:0] n;
    logic [4:0] m;
    n = prbs_len(sel);
    m = prbs_mid(sel);
    return h[n - 5'd1] ^ h[m - 5'd1];
  endfunction

  // step a bit pointer down through the word, wrapping at zero
  function automatic logic [4:0] ptr_dec(input logic [4:0] p,
                                         input logic [4:0] top);
    return (p == 5'd0) ? top : p - 5'd1;
  endfunction

endpackage

// File: rtl/patchk_prbs_ref.sv
module patchk_prbs_ref
  import patchk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             load,
  input  logic             rx_bit,
  input  logic [SEL_W-1:0] sel,
  output logic             exp_bit
);

  logic [HIST_W-1:0] hist;

  assign exp_bit = prbs_fb(hist, sel);

  // feed-forward: while loading, received bits enter the register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist <= '1;
    end else if (adv) begin
      hist <= {hist[HIST_W-2:0], (load ? rx_bit : exp_bit)};
    end
  end

endmodule

// File: rtl/patchk_word_ref.sv
module patchk_word_ref
  import patchk_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              slip,
  input  logic [WORD_W-1:0] word_pat,
  output logic              exp_bit
);

  localparam int PTR_W = $clog2(WORD_W);
  localparam logic [4:0] PTR_TOP = 5'(WORD_W - 1);

  logic [PTR_W-1:0] ptr;
  logic [4:0]       ptr_ext;
  logic [4:0]       ptr_nxt;

  assign ptr_ext = 5'(ptr);
  assign ptr_nxt = ptr_dec(ptr_ext, PTR_TOP);
  assign exp_bit = word_pat[ptr];

  // a slip holds the pointer for one bit, delaying the reference
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= PTR_W'(WORD_W - 1);
    end else if (adv && !slip) begin
      ptr <= ptr_nxt[PTR_W-1:0];
    end
  end

endmodule

// File: rtl/patchk_win_mon.sv
module patchk_win_mon #(
  parameter int WIN_LEN = 256,
  parameter int ERR_W   = $clog2(WIN_LEN + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             cnt_en,
  input  logic             miss,
  input  logic [ERR_W-1:0] thr,
  output logic             win_end,
  output logic             win_bad
);

  localparam int BCNT_W = $clog2(WIN_LEN);
  localparam logic [BCNT_W-1:0] BCNT_LAST = BCNT_W'(WIN_LEN - 1);

  logic [BCNT_W-1:0] bcnt;
  logic [ERR_W-1:0]  ecnt;
  logic [ERR_W-1:0]  err_tot;
  logic              last;

  assign last    = (bcnt == BCNT_LAST);
  assign err_tot = ecnt + ERR_W'(miss);
  assign win_end = cnt_en && last;
  assign win_bad = win_end && (err_tot >= thr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bcnt <= '0;
      ecnt <= '0;
    end else if (clr) begin
      bcnt <= '0;
      ecnt <= '0;
    end else if (cnt_en) begin
      if (last) begin
        bcnt <= '0;
        ecnt <= '0;
      end else begin
        bcnt <= bcnt + BCNT_W'(1);
        ecnt <= err_tot;
      end
    end
  end

endmodule

// File: rtl/patchk_err_cnt.sv
module patchk_err_cnt #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);

  logic at_max;
  assign at_max = (count == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
    end else if (clr) begin
      count <= '0;
    end else if (inc && !at_max) begin
      count <= count + CNT_W'(1);
    end
  end

endmodule

// File: rtl/patchk_top.sv
module patchk_top
  import patchk_pkg::*;
#(
  parameter int WORD_W   = 16,
  parameter int WIN_LEN  = 256,
  parameter int PRBS_THR = 64,
  parameter int WORD_THR = 8,
  parameter int CNT_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              rx_bit,
  input  logic              mode_word,
  input  logic [SEL_W-1:0]  prbs_sel,
  input  logic [WORD_W-1:0] word_pat,
  input  logic              cnt_clear,
  output logic              locked,
  output logic              err_pulse,
  output logic [CNT_W-1:0]  err_count
);

  localparam int ERR_W = $clog2(WIN_LEN + 1);

  sync_st_e   st;
  sync_st_e   st_nxt;
  logic [4:0] seed_cnt;
  logic [4:0] seed_last;

  // named internal events
  logic cmp_en;
  logic seed_load;
  logic miss;
  logic slip;
  logic win_end;
  logic win_bad;
  logic prbs_exp;
  logic word_exp;
  logic exp_bit;
  logic active;
  logic [ERR_W-1:0] thr;

  assign active    = (st != ST_IDLE);
  assign seed_load = bit_valid && (st == ST_SEED);
  assign cmp_en    = bit_valid && ((st == ST_HUNT) || (st == ST_LOCK));
  assign exp_bit   = mode_word ? word_exp : prbs_exp;
  assign miss      = cmp_en && (rx_bit != exp_bit);
  assign slip      = mode_word && win_bad;
  assign thr       = mode_word ? ERR_W'(WORD_THR) : ERR_W'(PRBS_THR);
  assign seed_last = prbs_len(prbs_sel) - 5'd1;
  assign locked    = (st == ST_LOCK);

  patchk_prbs_ref u_prbs (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (bit_valid && !mode_word && active),
    .load    (st == ST_SEED),
    .rx_bit  (rx_bit),
    .sel     (prbs_sel),
    .exp_bit (prbs_exp)
  );

  patchk_word_ref #(.WORD_W(WORD_W)) u_word (
    .clk      (clk),
    .rst_n    (rst_n),
    .adv      (bit_valid && mode_word && active),
    .slip     (slip),
    .word_pat (word_pat),
    .exp_bit  (word_exp)
  );

  patchk_win_mon #(.WIN_LEN(WIN_LEN), .ERR_W(ERR_W)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!((st == ST_HUNT) || (st == ST_LOCK))),
    .cnt_en  (cmp_en),
    .miss    (miss),
    .thr     (thr),
    .win_end (win_end),
    .win_bad (win_bad)
  );

  patchk_err_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clear),
    .inc   (miss && (st == ST_LOCK)),
    .count (err_count)
  );

  // acquisition sequence
  always_comb begin
    st_nxt = st;
    case (st)
      ST_IDLE: st_nxt = mode_word ? ST_HUNT : ST_SEED;
      ST_SEED: if (bit_valid && (seed_cnt == seed_last)) st_nxt = ST_HUNT;
      ST_HUNT: if (win_end) begin
                 if (!win_bad)      st_nxt = ST_LOCK;
                 else if (!mode_word) st_nxt = ST_SEED;
               end
      ST_LOCK: if (win_bad) st_nxt = mode_word ? ST_HUNT : ST_SEED;
      default: st_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      seed_cnt  <= '0;
      err_pulse <= 1'b0;
    end else begin
      st        <= st_nxt;
      err_pulse <= miss && (st == ST_LOCK);
      if (st != ST_SEED) begin
        seed_cnt <= '0;
      end else if (bit_valid) begin
        seed_cnt <= (seed_cnt == seed_last) ? 5'd0 : seed_cnt + 5'd1;
      end
    end
  end

endmodule

// File: rtl/patchk_sva.sv
module patchk_sva #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bit_valid,
  input logic             cnt_clear,
  input logic             mode_word,
  input logic             locked,
  input logic             err_pulse,
  input logic [CNT_W-1:0] err_count,
  input logic             win_end,
  input logic             win_bad,
  input logic             slip
);

  p_pulse_after_bit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(bit_valid));

  p_pulse_when_locked_r7: assert property (@(posedge clk) disable iff (!rst_n)
    err_pulse |-> $past(locked));

  p_count_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clear |=> (err_count == $past(err_count)) ||
                   (err_count == $past(err_count) + CNT_W'(1)));

  p_count_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && !cnt_clear) |=> $stable(err_count));

  p_count_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear |=> (err_count == '0));

  p_count_sat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((err_count == '1) && !cnt_clear) |=> (err_count == '1));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!bit_valid && !cnt_clear && !win_end) |=> $stable(err_count) && !err_pulse);

  p_lock_on_clean_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(win_end && !win_bad));

  p_drop_on_bad_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && win_bad) |=> !locked);

  p_slip_word_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    slip |-> mode_word);

  p_window_needs_bit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    win_end |-> bit_valid);

endmodule

bind patchk_top patchk_sva #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bit_valid (bit_valid),
  .cnt_clear (cnt_clear),
  .mode_word (mode_word),
  .locked    (locked),
  .err_pulse (err_pulse),
  .err_count (err_count),
  .win_end   (win_end),
  .win_bad   (win_bad),
  .slip      (slip)
);

// File: tb/tb_patchk_top.sv
`timescale 1ns/1ps
module tb_patchk_top;

  localparam int CLK_PERIOD = 10;
  localparam int SAT_W      = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_valid = 1'b0;
  logic        rx_bit = 1'b0;
  logic        mode_word = 1'b0;
  logic [2:0]  prbs_sel = 3'd0;
  logic [15:0] word_pat = 16'h8CA7;
  logic        cnt_clear = 1'b0;
  logic        locked;
  logic        err_pulse;
  logic [31:0] err_count;
  logic        locked_s;
  logic        pulse_s;
  logic [SAT_W-1:0] cnt_s;

  int nchk  = 0;
  int nfail = 0;
  int bidx  = 0;
  logic [22:0] tb_hist;

  always #(CLK_PERIOD/2) clk = ~clk;

  patchk_top dut (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .rx_bit(rx_bit),
    .mode_word(mode_word), .prbs_sel(prbs_sel), .word_pat(word_pat),
    .cnt_clear(cnt_clear), .locked(locked), .err_pulse(err_pulse),
    .err_count(err_count)
  );

  patchk_top #(.CNT_W(SAT_W)) dut_sat (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .rx_bit(rx_bit),
    .mode_word(mode_word), .prbs_sel(prbs_sel), .word_pat(word_pat),
    .cnt_clear(cnt_clear), .locked(locked_s), .err_pulse(pulse_s),
    .err_count(cnt_s)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s at bit %0d: actual %0d expected %0d", tag, bidx, act, exp);
    end
  endtask

  // order and tap tables, written from R1
  function automatic int ord_n(input int s);
    int t[5] = '{7, 15, 17, 20, 23};
    return t[s];
  endfunction
  function automatic int ord_m(input int s);
    int t[5] = '{6, 14, 14, 3, 18};
    return t[s];
  endfunction

  // transmitter model: newest bit at index 0
  function automatic logic tx_prbs(input int s);
    logic b;
    b = tb_hist[ord_n(s)-1] ^ tb_hist[ord_m(s)-1];
    tb_hist = {tb_hist[21:0], b};
    return b;
  endfunction

  function automatic logic tx_word(input int p);
    return word_pat[15 - ((bidx + p) % 16)];
  endfunction

  task automatic do_reset(input logic wmode, input logic [2:0] sel);
    @(negedge clk);
    rst_n = 1'b0; bit_valid = 1'b0; cnt_clear = 1'b0;
    mode_word = wmode; prbs_sel = sel;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    bidx = 0;
    tb_hist = 23'h5A5A5A;
  endtask

  // one bit per call; returns at the falling edge after it was taken
  task automatic push(input logic b);
    rx_bit = b; bit_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bit_valid = 1'b0;
    bidx++;
  endtask

  task automatic idle(input int cycles, input logic noise);
    for (int i = 0; i < cycles; i++) begin
      rx_bit = noise ^ i[0];
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic t_reset_state;
    do_reset(1'b0, 3'd0);
    chk(locked == 1'b0, "R11 locked after reset", locked, 0);
    chk(err_pulse == 1'b0, "R11 err_pulse after reset", err_pulse, 0);
    chk(err_count == 0, "R11 err_count after reset", err_count, 0);
  endtask

  task automatic t_prbs_orders;
    for (int s = 0; s < 5; s++) begin
      int n;
      n = ord_n(s);
      do_reset(1'b0, 3'(s));
      for (int k = 0; k <= n + 255; k++) begin
        push(tx_prbs(s));
        if (k == n + 254) chk(locked == 1'b0, "R1 R2 no lock before window end", locked, 0);
        if (k == n + 255) chk(locked == 1'b1, "R1 R2 lock at n+255", locked, 1);
      end
      chk(err_count == 0, "R8 no errors counted on clean lock", err_count, 0);
    end
  endtask

  task automatic t_prbs_loss;
    logic e;
    do_reset(1'b0, 3'd0);
    for (int k = 0; k <= 1037; k++) begin
      e = ((k >= 300) && (k <= 362)) || ((k >= 600) && (k <= 663));
      push(tx_prbs(0) ^ e);
      if (k == 518) begin
        chk(locked == 1'b1, "R3 63 errors keep lock", locked, 1);
        chk(err_count == 63, "R8 count after 63 errors", err_count, 63);
        chk(cnt_s == 6'd63, "R9 narrow count at max", cnt_s, 63);
      end
      if (k == 774) begin
        chk(locked == 1'b0, "R3 64 errors drop lock", locked, 0);
        chk(err_count == 127, "R8 count after 127 errors", err_count, 127);
        chk(cnt_s == 6'd63, "R9 narrow count saturates", cnt_s, 63);
      end
      if (k == 1036) begin
        chk(locked == 1'b0, "R2 no relock before reseed window", locked, 0);
        chk(err_count == 127, "R8 count frozen while resyncing", err_count, 127);
      end
      if (k == 1037) chk(locked == 1'b1, "R2 relock after reseed", locked, 1);
    end
    // clear while an error is counted: the clear wins
    rx_bit = ~tx_prbs(0); bit_valid = 1'b1; cnt_clear = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bit_valid = 1'b0; cnt_clear = 1'b0; bidx++;
    chk(err_count == 0, "R9 clear beats increment", err_count, 0);
    chk(cnt_s == 0, "R9 narrow count cleared", cnt_s, 0);
  endtask

  task automatic t_prbs_inverted;
    int seen;
    seen = 0;
    do_reset(1'b0, 3'd1);
    for (int k = 0; k < 1200; k++) begin
      push(~tx_prbs(1));
      if (locked) seen++;
    end
    chk(seen == 0, "R2 inverted stream never locks", seen, 0);
    chk(err_count == 0, "R8 no count while unlocked", err_count, 0);
  endtask

  task automatic t_idle_gaps;
    do_reset(1'b0, 3'd2);
    for (int k = 0; k <= 272; k++) begin
      push(tx_prbs(2));
      if (k % 8 == 7) idle(3, 1'b1);
      if (k == 271) chk(locked == 1'b0, "R10 gaps do not shorten acquisition", locked, 0);
      if (k == 272) chk(locked == 1'b1, "R10 lock at n+255 with gaps", locked, 1);
    end
    begin
      int pulses;
      pulses = 0;
      for (int i = 0; i < 20; i++) begin
        rx_bit = i[0]; bit_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        if (err_pulse) pulses++;
      end
      chk(pulses == 0, "R10 no pulse on idle cycles", pulses, 0);
    end
    for (int k = 0; k < 300; k++) push(tx_prbs(2));
    chk(locked == 1'b1, "R10 reference did not move while idle", locked, 1);
    chk(err_count == 0, "R10 no count from idle noise", err_count, 0);
  endtask

  task automatic t_word_loss;
    logic e;
    do_reset(1'b1, 3'd0);
    for (int k = 0; k <= 4863; k++) begin
      e = ((k >= 300) && (k <= 312) && (k % 2 == 0)) || ((k >= 600) && (k <= 607));
      push(tx_word(0) ^ e);
      if (k == 254) chk(locked == 1'b0, "R4 not locked before first window end", locked, 0);
      if (k == 255) chk(locked == 1'b1, "R4 aligned word locks at 255", locked, 1);
      if (k == 300) chk(err_pulse == 1'b1, "R7 pulse after error", err_pulse, 1);
      if (k == 301) chk(err_pulse == 1'b0, "R7 no pulse after clean bit", err_pulse, 0);
      if (k == 511) begin
        chk(locked == 1'b1, "R6 7 errors keep lock", locked, 1);
        chk(err_count == 7, "R8 count of 7", err_count, 7);
      end
      if (k == 767) begin
        chk(locked == 1'b0, "R6 8 errors drop lock", locked, 0);
        chk(err_count == 15, "R8 count of 15", err_count, 15);
      end
      if (k == 4862) begin
        chk(locked == 1'b0, "R5 still slipping", locked, 0);
        chk(err_count == 15, "R8 count frozen during slips", err_count, 15);
        chk(err_pulse == 1'b0, "R7 no pulse while unlocked", err_pulse, 0);
      end
      if (k == 4863) chk(locked == 1'b1, "R5 relock after full slip cycle", locked, 1);
    end
  endtask

  task automatic t_word_phase;
    do_reset(1'b1, 3'd0);
    for (int k = 0; k <= 3583; k++) begin
      push(tx_word(3));
      if (k == 3582) chk(locked == 1'b0, "R5 phase 3 not locked early", locked, 0);
      if (k == 3583) chk(locked == 1'b1, "R5 phase 3 locks after 13 slips", locked, 1);
    end
    chk(err_count == 0, "R8 slip errors not counted", err_count, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_prbs_orders();
    t_prbs_loss();
    t_prbs_inverted();
    t_idle_gaps();
    t_word_loss();
    t_word_phase();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

endmodule